// File: doc/BRIEF.md
# Multithreaded Fetch Queue Dispatcher

This block sits between instruction fetch and decode in a core that runs several hardware threads at once. Every thread has its own instruction queue, and all queues share one capacity limit. Fetch pushes at most one instruction per thread per cycle. Each cycle the block fills a decode bundle of up to `DEC_WIDTH` slots, and it takes instructions from several threads so that no single thread owns the decode bandwidth.

Draining starts at a pseudo-randomly chosen schedulable thread. It then steps through the schedulable threads in ascending index order and wraps around, taking one instruction from each thread it visits. A thread that is stalled or empty is skipped. A squash or a deactivation empties only the queue of the affected thread. A deactivated thread leaves the schedule set until upstream drops its active bit and raises it again, so a stale active bit can never lead to a dispatch. The block also reports when it is drained and raises an activity flag in every cycle in which it dispatches.

Top module: `fqd_dispatch`

## Requirements
- R1: `q_full_o[t]` is 1 exactly when thread t holds `Q_DEPTH` entries. An enqueue that arrives while the flag is 1 is dropped, even if the same cycle also pops from that queue.
- R2: At most `DEC_WIDTH` slots are valid per cycle. Valid slots are packed from slot 0 upward with no gaps.
- R3: The number of valid slots equals min(`DEC_WIDTH`, total entries held by threads that are schedulable, not decode-stalled and not being squashed).
- R4: The schedule set is `active_i` with deactivated threads removed. Let n be the size of the set. The drain starts at the k-th set member, counted by ascending index from 0, where k = L mod n. L is a 16-bit register that resets to 0xACE1 and, every cycle out of reset, shifts left by one bit, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. From the start thread the drain visits set members in ascending index order with wraparound. Each visit takes at most one instruction, and only from a thread that is not stalled and not empty.
- R5: `squash_i[t]` empties queue t at the next edge and leaves the other queues unchanged. An enqueue to thread t in the same cycle is discarded. Thread t dispatches nothing in the squash cycle.
- R6: `deact_valid_i` with `deact_tid_i` = t removes thread t from the schedule set from that cycle on, until `active_i[t]` has been low at a clock edge. The strobe also empties queue t and discards an enqueue to t in that cycle. Enqueues in later cycles are accepted but not dispatched.
- R7: `drained_o` is 1 exactly when every queue is empty and, for every thread, `idle_i` or `drain_hold_i` is 1.
- R8: `activity_o` is 1 exactly in cycles where at least one decode slot is valid.
- R9: During reset every queue is empty, so all full flags and all slot valids are 0.
- R10: Instructions of one thread leave in arrival order. Each valid slot carries the thread index in its `dec_tid_o` field, and slot s occupies bits [s*TID_W +: TID_W] of that port and [s*INSN_W +: INSN_W] of `dec_insn_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | NUM_THREADS | Per-thread enqueue request |
| enq_insn_i | input | NUM_THREADS*INSN_W | Per-thread instruction word, thread t at [t*INSN_W +: INSN_W] |
| active_i | input | NUM_THREADS | Threads enabled by upstream |
| dec_stall_i | input | NUM_THREADS | Per-thread decode stall |
| squash_i | input | NUM_THREADS | Per-thread squash strobe |
| deact_valid_i | input | 1 | Deactivate strobe |
| deact_tid_i | input | TID_W | Thread addressed by the deactivate strobe |
| idle_i | input | NUM_THREADS | Thread fetch is idle |
| drain_hold_i | input | NUM_THREADS | Thread is blocked by a drain request |
| q_full_o | output | NUM_THREADS | Per-thread queue full |
| dec_valid_o | output | DEC_WIDTH | Decode slot valid |
| dec_insn_o | output | DEC_WIDTH*INSN_W | Decode slot instruction words |
| dec_tid_o | output | DEC_WIDTH*TID_W | Decode slot thread index |
| drained_o | output | 1 | Queues empty and all threads quiescent |
| activity_o | output | 1 | At least one slot dispatched this cycle |

## Verification
The bench sweeps every pair of active mask and stall mask for a four-thread, depth-four, two-slot configuration. Queues are refilled between steps, so each combination is seen with a different start value. This separates a correct random start and wraparound order from a fixed-priority or lowest-index order, and a count over eligible threads from a count over all threads. A pattern with a single busy thread shows that one thread can fill several slots in a cycle. Squash and deactivation patterns that collide with enqueues show whether a purge stays on its own thread and whether a stale active bit leaks into dispatch. A full sweep of the idle and hold masks, with queues empty and then non-empty, covers the drained output.

// File: rtl/fqd_pkg.sv
package fqd_pkg;
  localparam int              LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  // feedback from bits 15, 13, 12, 10
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  function automatic int clog2_min1(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/fqd_lfsr.sv
module fqd_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   SEED = '1,
  parameter logic [W-1:0]   TAPS = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] val_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign val_o = q;
endmodule

// File: rtl/fqd_thread_queue.sv
module fqd_thread_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int PEEK  = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  push_i,
  input  logic [W-1:0]          data_i,
  input  logic [CW-1:0]         pop_i,
  output logic [PEEK-1:0][W-1:0] peek_o,
  output logic [CW-1:0]         cnt_o,
  output logic                  full_o
);
  localparam int HW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [HW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok;
  int            tail;
  int            nhead;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign tail    = (int'(head_q) + int'(cnt_q)) % DEPTH;
  assign nhead   = (int'(head_q) + int'(pop_i)) % DEPTH;

  always_comb begin
    for (int r = 0; r < PEEK; r++) peek_o[r] = mem[(int'(head_q) + r) % DEPTH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= HW'(nhead);
      cnt_q  <= cnt_q - pop_i + CW'(push_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[tail] <= data_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fqd_slot_picker.sv
module fqd_slot_picker #(
  parameter int T  = 4,
  parameter int DW = 4,
  parameter int W  = 32,
  parameter int CW = 4,
  parameter int TW = 2,
  parameter int RW = 16
) (
  input  logic [T-1:0]                  sched_i,
  input  logic [T-1:0][CW-1:0]          avail_i,
  input  logic [RW-1:0]                 rnd_i,
  input  logic [T-1:0][DW-1:0][W-1:0]   peek_i,
  output logic [DW-1:0]                 valid_o,
  output logic [DW-1:0][W-1:0]          insn_o,
  output logic [DW-1:0][TW-1:0]         tid_o,
  output logic [T-1:0][CW-1:0]          pop_o
);
  always_comb begin
    int n_act;
    int k;
    int seen;
    int start;
    int slot;
    int t;
    valid_o = '0;
    insn_o  = '0;
    tid_o   = '0;
    pop_o   = '0;
    n_act   = 0;
    for (int i = 0; i < T; i++) n_act += int'(sched_i[i]);
    k     = (n_act == 0) ? 0 : int'(rnd_i) % n_act;
    seen  = 0;
    start = 0;
    for (int i = 0; i < T; i++) begin
      if (sched_i[i]) begin
        if (seen == k) start = i;
        seen++;
      end
    end
    // round r takes the r-th entry of every thread still holding one
    slot = 0;
    for (int r = 0; r < DW; r++) begin
      for (int p = 0; p < T; p++) begin
        t = (start + p) % T;
        if (int'(avail_i[t]) > r && slot < DW) begin
          valid_o[slot] = 1'b1;
          insn_o[slot]  = peek_i[t][r];
          tid_o[slot]   = TW'(t);
          pop_o[t]      = pop_o[t] + CW'(1);
          slot++;
        end
      end
    end
  end
endmodule

// File: rtl/fqd_dispatch.sv
module fqd_dispatch
  import fqd_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int Q_DEPTH     = 8,
  parameter int DEC_WIDTH   = 4,
  parameter int INSN_W      = 32,
  localparam int TID_W      = clog2_min1(NUM_THREADS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_THREADS-1:0]        enq_valid_i,
  input  logic [NUM_THREADS*INSN_W-1:0] enq_insn_i,
  input  logic [NUM_THREADS-1:0]        active_i,
  input  logic [NUM_THREADS-1:0]        dec_stall_i,
  input  logic [NUM_THREADS-1:0]        squash_i,
  input  logic                          deact_valid_i,
  input  logic [TID_W-1:0]              deact_tid_i,
  input  logic [NUM_THREADS-1:0]        idle_i,
  input  logic [NUM_THREADS-1:0]        drain_hold_i,
  output logic [NUM_THREADS-1:0]        q_full_o,
  output logic [DEC_WIDTH-1:0]          dec_valid_o,
  output logic [DEC_WIDTH*INSN_W-1:0]   dec_insn_o,
  output logic [DEC_WIDTH*TID_W-1:0]    dec_tid_o,
  output logic                          drained_o,
  output logic                          activity_o
);
  localparam int T  = NUM_THREADS;
  localparam int DW = DEC_WIDTH;
  localparam int CW = $clog2(Q_DEPTH + 1);

  logic [T-1:0]                    deact_hit;
  logic [T-1:0]                    retired_q;
  logic [T-1:0]                    sched;
  logic [T-1:0]                    flush;
  logic [T-1:0]                    q_empty;
  logic [T-1:0][CW-1:0]            q_cnt;
  logic [T-1:0][CW-1:0]            avail;
  logic [T-1:0][CW-1:0]            pop;
  logic [T-1:0][DW-1:0][INSN_W-1:0] peek;
  logic [DW-1:0][INSN_W-1:0]       slot_insn;
  logic [DW-1:0][TID_W-1:0]        slot_tid;
  logic [LFSR_W-1:0]               rnd;

  fqd_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .val_o  (rnd)
  );

  for (genvar t = 0; t < T; t++) begin : g_thr
    assign deact_hit[t] = deact_valid_i && (int'(deact_tid_i) == t);
    assign sched[t]     = active_i[t] & ~retired_q[t] & ~deact_hit[t];
    assign flush[t]     = squash_i[t] | deact_hit[t];
    assign avail[t]     = (sched[t] & ~dec_stall_i[t] & ~squash_i[t]) ? q_cnt[t] : '0;
    assign q_empty[t]   = (q_cnt[t] == '0);

    // stays out of the schedule set until upstream drops the active bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            retired_q[t] <= 1'b0;
      else if (deact_hit[t])  retired_q[t] <= 1'b1;
      else if (!active_i[t])  retired_q[t] <= 1'b0;
    end

    fqd_thread_queue #(
      .DEPTH (Q_DEPTH),
      .W     (INSN_W),
      .PEEK  (DW),
      .CW    (CW)
    ) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush[t]),
      .push_i  (enq_valid_i[t]),
      .data_i  (enq_insn_i[t*INSN_W +: INSN_W]),
      .pop_i   (pop[t]),
      .peek_o  (peek[t]),
      .cnt_o   (q_cnt[t]),
      .full_o  (q_full_o[t])
    );
  end

  fqd_slot_picker #(
    .T  (T),
    .DW (DW),
    .W  (INSN_W),
    .CW (CW),
    .TW (TID_W),
    .RW (LFSR_W)
  ) u_pick (
    .sched_i (sched),
    .avail_i (avail),
    .rnd_i   (rnd),
    .peek_i  (peek),
    .valid_o (dec_valid_o),
    .insn_o  (slot_insn),
    .tid_o   (slot_tid),
    .pop_o   (pop)
  );

  assign dec_insn_o = slot_insn;
  assign dec_tid_o  = slot_tid;
  assign drained_o  = (&q_empty) & (&(idle_i | drain_hold_i));
  assign activity_o = |dec_valid_o;
endmodule

// File: rtl/fqd_dispatch_chk.sv
module fqd_dispatch_chk #(
  parameter int NUM_THREADS = 4,
  parameter int Q_DEPTH     = 8,
  parameter int DEC_WIDTH   = 4,
  parameter int TID_W       = 2,
  localparam int CW         = $clog2(Q_DEPTH + 1)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_THREADS-1:0]        active_i,
  input logic [NUM_THREADS-1:0]        dec_stall_i,
  input logic [NUM_THREADS-1:0]        squash_i,
  input logic                          deact_valid_i,
  input logic [TID_W-1:0]              deact_tid_i,
  input logic [DEC_WIDTH-1:0]          dec_valid_o,
  input logic [DEC_WIDTH*TID_W-1:0]    dec_tid_o,
  input logic                          drained_o,
  input logic                          activity_o,
  input logic [NUM_THREADS-1:0][CW-1:0] q_cnt_i
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_cnt_i[t] <= CW'(Q_DEPTH)); // R1
    AST_SQUASH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_i[t] |=> (q_cnt_i[t] == '0)); // R5
  end

  for (genvar s = 0; s < DEC_WIDTH; s++) begin : g_s
    if (s > 0) begin : g_pk
      AST_SLOTS_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_o[s] |-> dec_valid_o[s-1]); // R2
    end
    AST_TID_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_valid_o[s] |-> (active_i[dec_tid_o[s*TID_W +: TID_W]] &&
                          !dec_stall_i[dec_tid_o[s*TID_W +: TID_W]] &&
                          !squash_i[dec_tid_o[s*TID_W +: TID_W]])); // R4
    AST_DEACT_EXCLUDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_valid_o[s] && deact_valid_i) |-> (dec_tid_o[s*TID_W +: TID_W] != deact_tid_i)); // R6
  end

  AST_DRAINED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> (dec_valid_o == '0)); // R7
  AST_ACTIVITY_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_o == dec_valid_o[0]); // R8
endmodule

bind fqd_dispatch fqd_dispatch_chk #(
  .NUM_THREADS (NUM_THREADS),
  .Q_DEPTH     (Q_DEPTH),
  .DEC_WIDTH   (DEC_WIDTH),
  .TID_W       (TID_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .active_i      (active_i),
  .dec_stall_i   (dec_stall_i),
  .squash_i      (squash_i),
  .deact_valid_i (deact_valid_i),
  .deact_tid_i   (deact_tid_i),
  .dec_valid_o   (dec_valid_o),
  .dec_tid_o     (dec_tid_o),
  .drained_o     (drained_o),
  .activity_o    (activity_o),
  .q_cnt_i       (q_cnt)
);

// File: tb/fqd_dispatch_tb_top.sv
`timescale 1ns/1ps
module fqd_dispatch_tb_top;
  localparam int T  = 4;
  localparam int D  = 4;
  localparam int DW = 2;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [T-1:0]  enq_v = '0, act = '0, stl = '0, sq = '0, idl = '1, hld = '0;
  logic          dv = 1'b0;
  logic [1:0]    dt = '0;
  logic [W-1:0]  enq_d [T];
  logic [T*W-1:0] enq_bus;
  logic [T-1:0]  full;
  logic [DW-1:0] dvalid;
  logic [DW*W-1:0] dinsn;
  logic [DW*2-1:0] dtid;
  logic          drained, activity;

  int n_cmp = 0, n_bad = 0;
  int seqn [T];
  logic [W-1:0] mq [T][D];
  int mc [T];
  logic [T-1:0] mret = '0;
  logic [15:0]  lf = 16'hACE1;

  always #4 clk = ~clk;

  always_comb for (int t = 0; t < T; t++) enq_bus[t*W +: W] = enq_d[t];

  fqd_dispatch #(
    .NUM_THREADS (T),
    .Q_DEPTH     (D),
    .DEC_WIDTH   (DW),
    .INSN_W      (W)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .enq_valid_i   (enq_v),
    .enq_insn_i    (enq_bus),
    .active_i      (act),
    .dec_stall_i   (stl),
    .squash_i      (sq),
    .deact_valid_i (dv),
    .deact_tid_i   (dt),
    .idle_i        (idl),
    .drain_hold_i  (hld),
    .q_full_o      (full),
    .dec_valid_o   (dvalid),
    .dec_insn_o    (dinsn),
    .dec_tid_o     (dtid),
    .drained_o     (drained),
    .activity_o    (activity)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [T-1:0] dh, s_set, exp_full;
    int left [T];
    int taken [T];
    int total, n, k, seen, cur, ns, ofs;
    logic [W-1:0] ed [DW];
    int et [DW];
    logic exp_drn;
    for (int t = 0; t < T; t++) enq_d[t] = {2'(t), 14'(seqn[t])};
    #1;
    dh = dv ? 4'(1 << dt) : 4'b0;
    s_set = act & ~mret & ~dh;
    total = 0; n = 0;
    for (int t = 0; t < T; t++) begin
      left[t]  = (s_set[t] && !stl[t] && !sq[t]) ? mc[t] : 0;
      taken[t] = 0;
      total   += left[t];
      n       += int'(s_set[t]);
    end
    ns = 0;
    if (n > 0) begin
      k = int'(lf) % n; seen = 0; cur = 0;
      for (int t = 0; t < T; t++) if (s_set[t]) begin
        if (seen == k) cur = t;
        seen++;
      end
      while (total > 0 && ns < DW) begin
        if (left[cur] > 0) begin
          ed[ns] = mq[cur][taken[cur]]; et[ns] = cur;
          taken[cur]++; left[cur]--; total--; ns++;
        end
        for (int j = 1; j <= T; j++) if (s_set[(cur + j) % T]) begin
          cur = (cur + j) % T; break;
        end
      end
    end
    chk(dvalid == DW'((1 << ns) - 1), {tag, " R2 R3"}, "slot valid mask",
        int'(dvalid), (1 << ns) - 1);
    for (int s = 0; s < DW; s++) if (s < ns) begin
      chk(dinsn[s*W +: W] == ed[s], {tag, " R4 R10"}, $sformatf("slot%0d insn", s),
          int'(dinsn[s*W +: W]), int'(ed[s]));
      chk(int'(dtid[s*2 +: 2]) == et[s], {tag, " R4 R10"}, $sformatf("slot%0d tid", s),
          int'(dtid[s*2 +: 2]), et[s]);
    end
    chk(activity == (ns > 0), "R8", "activity", int'(activity), int'(ns > 0));
    exp_drn = &(idl | hld);
    for (int t = 0; t < T; t++) begin
      exp_full[t] = (mc[t] == D);
      if (mc[t] != 0) exp_drn = 1'b0;
    end
    chk(full == exp_full, "R1", "full flags", int'(full), int'(exp_full));
    chk(drained == exp_drn, "R7", "drained", int'(drained), int'(exp_drn));
    @(posedge clk);
    for (int t = 0; t < T; t++) begin
      if (sq[t] || dh[t]) mc[t] = 0;
      else begin
        ofs = mc[t];
        for (int i = 0; i + taken[t] < D; i++) mq[t][i] = mq[t][i + taken[t]];
        mc[t] = mc[t] - taken[t];
        if (enq_v[t] && ofs < D) begin
          mq[t][mc[t]] = enq_d[t];
          mc[t]++;
        end
      end
      if (enq_v[t]) seqn[t]++;
      if (dh[t]) mret[t] = 1'b1;
      else if (!act[t]) mret[t] = 1'b0;
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R3", "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < T; t++) begin seqn[t] = 0; mc[t] = 0; enq_d[t] = '0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(dvalid == '0, "R9", "reset valid", int'(dvalid), 0);
    chk(full == '0, "R9", "reset full", int'(full), 0);
    chk(activity == 1'b0, "R9", "reset activity", int'(activity), 0);
    chk(drained == 1'b1, "R9", "reset drained", int'(drained), 1);
    rst_n = 1'b1;

    // R1: fill every queue with decode stalled, then overrun
    act = '1; stl = '1; enq_v = '1;
    repeat (6) step("R1");
    enq_v = '0; stl = '0;
    repeat (5) step("R10");

    // single busy thread fills several slots in one cycle
    act = 4'b0100; enq_v = 4'b0100; stl = '0;
    repeat (3) step("R4");
    enq_v = '0;
    repeat (3) step("R4");

    // R3/R4: sweep every active and stall mask
    for (int am = 1; am < 16; am++) begin
      for (int sm = 0; sm < 16; sm++) begin
        act = 4'(am); stl = 4'(sm); enq_v = '1;
        step("R3");
        enq_v = ~4'(sm);
        step("R4");
      end
    end

    // R5: squash collides with enqueue, one thread at a time
    act = '1; stl = '1; enq_v = '1;
    repeat (3) step("R5");
    for (int t = 0; t < T; t++) begin
      sq = 4'(1 << t); stl = 4'(t[0] ? 4'b0000 : 4'b1010);
      step("R5");
      sq = '0; enq_v = '1;
      step("R5");
    end
    stl = '0; enq_v = '0;
    repeat (4) step("R5");

    // R6: deactivate thread 2 while active stays high
    act = '1; enq_v = '1; stl = '0;
    repeat (2) step("R6");
    dv = 1'b1; dt = 2'd2;
    step("R6");
    dv = 1'b0;
    repeat (8) step("R6");
    act = 4'b1011;
    step("R6");
    act = '1; enq_v = '0;
    repeat (10) step("R6");

    // R7: drained over all idle/hold masks, empty then non-empty
    for (int i = 0; i < 16; i++) begin
      for (int h = 0; h < 16; h++) begin
        idl = 4'(i); hld = 4'(h);
        step("R7");
      end
    end
    stl = '1; enq_v = 4'b0010;
    step("R7");
    enq_v = '0;
    for (int i = 0; i < 16; i++) begin
      idl = 4'(i); hld = ~4'(i);
      step("R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule